// File: doc/BRIEF.md
# Iterative Gate Netlist Evaluator

This block evaluates a small combinational network of two-input logic gates that is described as data rather than as hardware. A host loads a gate table, in which each entry gives an operation, two source wire indices and a destination wire index. It also presets the values of the primary input wires and fills a map that says which wire supplies each bit of the result word. A start pulse then sets the evaluator running.

Every wire is in one of three states: 0, 1 or not yet known. The evaluator walks the gate table one entry per clock. A pending gate fires only when both of its sources are known. A gate that has fired writes its destination once and is skipped after that. The evaluator repeats these sweeps until no gate is pending. It then gathers the mapped wires into the result word and pulses done.

Some netlists cannot be finished. These are a sweep that fires nothing while gates are still waiting, an illegal operation code, a second write to a wire that is already known, and a mapped output wire that ends unknown. Each of these stops the run with the error flag raised.

Top module: `netlist_eval`

## Requirements
- R1: The gate operation field is 2 bits: 00 gives AND, 01 gives OR and 10 gives XOR of the two source bits. When a pending entry holding code 11 is reached, the run stops with error set.
- R2: A gate fires only once both of its source wires are known. A chain listed in reverse dependency order still resolves, taking extra sweeps.
- R3: Each gate fires at most once per run, and every wire is written at most once. A gate whose destination is already known, either as a preset input or from another gate, stops the run with error set.
- R4: If a complete sweep fires no gate while at least one gate is still pending, the run stops with error set, and done is not pulsed.
- R5: Result bit k is taken from the wire that the map assigns to position k, with bit 0 as the least significant bit. Positions that have no map entry read as 0.
- R6: If any mapped wire is still unknown once all gates are done, the run ends with error instead of done.
- R7: Done is high for exactly one cycle. The result stays fixed after that until the next accepted start, which clears it to 0.
- R8: A start pulse while busy is ignored. Gate, wire, map and clear writes made while busy have no effect.
- R9: After reset, and after a clear pulse, no gates, no preset wires and no map entries exist. After reset, busy, done, error and result are all 0. A run on an empty table pulses done with result 0.
- R10: With gates x0 AND y0 -> z0, x1 XOR y1 -> z1 and x2 OR y2 -> z2, inputs x = 1,1,1 and y = 0,1,0, and z0..z2 mapped to positions 0..2, the result is 4.
- R11: Each accepted start returns every wire to its preset state, so that gate-derived values are forgotten. A repeated run reflects any inputs changed in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_clr | input | 1 | Clear gate table, wire presets and output map |
| gate_we | input | 1 | Write one gate table entry |
| gate_addr | input | GIW | Gate table entry index |
| gate_op | input | 2 | Operation code |
| gate_src_a | input | WIW | First source wire index |
| gate_src_b | input | WIW | Second source wire index |
| gate_dst | input | WIW | Destination wire index |
| wire_we | input | 1 | Preset a wire as a known input |
| wire_addr | input | WIW | Wire index to preset |
| wire_val | input | 1 | Preset value |
| map_we | input | 1 | Write one output map entry |
| map_pos | input | PIW | Result bit position |
| map_wire | input | WIW | Wire feeding that position |
| start | input | 1 | Begin evaluation |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Run aborted; held until next start |
| result | output | RES_W | Packed output word |

## Verification
The bench builds the block with 8 gate entries, 32 wires and a 16-bit result. With these sizes a sweep takes eight cycles, so runs that need several sweeps stay short. All four error causes can be reached with hand-built netlists, and the truth table of every operation can be checked directly. The small result width leaves room to show that unmapped upper positions stay 0, and to watch the cycle at which start clears the result.

// File: rtl/nl_pkg.sv
package nl_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_XOR = 2'b10,
    OP_BAD = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SWEEP = 2'b01,
    ST_PACK  = 2'b10
  } st_e;
endpackage

// File: rtl/nl_gate_table.sv
module nl_gate_table #(
  parameter int NG  = 256,
  parameter int NW  = 512,
  localparam int GIW = $clog2(NG),
  localparam int WIW = $clog2(NW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           we,
  input  logic [GIW-1:0] waddr,
  input  logic [1:0]     wop,
  input  logic [WIW-1:0] wsrc_a,
  input  logic [WIW-1:0] wsrc_b,
  input  logic [WIW-1:0] wdst,
  input  logic [GIW-1:0] raddr,
  output logic           r_present,
  output logic [1:0]     r_op,
  output logic [WIW-1:0] r_src_a,
  output logic [WIW-1:0] r_src_b,
  output logic [WIW-1:0] r_dst
);
  logic [NG-1:0]  present_q, present_d;
  logic [1:0]     op_q  [NG];
  logic [WIW-1:0] sa_q  [NG];
  logic [WIW-1:0] sb_q  [NG];
  logic [WIW-1:0] dst_q [NG];

  always_comb begin
    present_d = present_q;
    if (clr)     present_d = '0;
    else if (we) present_d[waddr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) present_q <= '0;
    else        present_q <= present_d;
  end

  always_ff @(posedge clk) begin
    if (we && !clr) begin
      op_q[waddr]  <= wop;
      sa_q[waddr]  <= wsrc_a;
      sb_q[waddr]  <= wsrc_b;
      dst_q[waddr] <= wdst;
    end
  end

  assign r_present = present_q[raddr];
  assign r_op      = op_q[raddr];
  assign r_src_a   = sa_q[raddr];
  assign r_src_b   = sb_q[raddr];
  assign r_dst     = dst_q[raddr];
endmodule

// File: rtl/nl_wire_store.sv
module nl_wire_store #(
  parameter int NW  = 512,
  localparam int WIW = $clog2(NW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           restore,
  input  logic           host_we,
  input  logic [WIW-1:0] host_addr,
  input  logic           host_val,
  input  logic           eng_we,
  input  logic [WIW-1:0] eng_addr,
  input  logic           eng_val,
  input  logic [WIW-1:0] rd_a,
  input  logic [WIW-1:0] rd_b,
  input  logic [WIW-1:0] rd_d,
  output logic           a_val,
  output logic           a_vld,
  output logic           b_val,
  output logic           b_vld,
  output logic           d_vld,
  output logic [NW-1:0]  val_vec,
  output logic [NW-1:0]  vld_vec
);
  logic [NW-1:0] val_q, val_d;
  logic [NW-1:0] vld_q, vld_d;
  logic [NW-1:0] pre_q, pre_d;

  always_comb begin
    val_d = val_q;
    vld_d = vld_q;
    pre_d = pre_q;
    if (clr) begin
      vld_d = '0;
      pre_d = '0;
    end else begin
      if (restore) vld_d = pre_q;
      if (host_we) begin
        val_d[host_addr] = host_val;
        vld_d[host_addr] = 1'b1;
        pre_d[host_addr] = 1'b1;
      end
      if (eng_we) begin
        val_d[eng_addr] = eng_val;
        vld_d[eng_addr] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      vld_q <= '0;
      pre_q <= '0;
    end else begin
      val_q <= val_d;
      vld_q <= vld_d;
      pre_q <= pre_d;
    end
  end

  assign a_val   = val_q[rd_a];
  assign a_vld   = vld_q[rd_a];
  assign b_val   = val_q[rd_b];
  assign b_vld   = vld_q[rd_b];
  assign d_vld   = vld_q[rd_d];
  assign val_vec = val_q;
  assign vld_vec = vld_q;

  // R3: the engine only ever writes a wire that is still unknown
  a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> !vld_q[eng_addr]);
endmodule

// File: rtl/nl_result_pack.sv
module nl_result_pack #(
  parameter int NW    = 512,
  parameter int RES_W = 64,
  localparam int WIW = $clog2(NW),
  localparam int PIW = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [PIW-1:0]   pos,
  input  logic [WIW-1:0]   wsel,
  input  logic [NW-1:0]    val_vec,
  input  logic [NW-1:0]    vld_vec,
  output logic [RES_W-1:0] packed_word,
  output logic             missing
);
  logic [RES_W-1:0] mask_q, mask_d;
  logic [WIW-1:0]   map_q [RES_W];
  logic [RES_W-1:0] miss_bits;

  always_comb begin
    mask_d = mask_q;
    if (clr)     mask_d = '0;
    else if (we) mask_d[pos] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_ff @(posedge clk) begin
    if (we && !clr) map_q[pos] <= wsel;
  end

  for (genvar k = 0; k < RES_W; k++) begin : g_bit
    assign packed_word[k] = mask_q[k] & val_vec[map_q[k]];
    assign miss_bits[k]   = mask_q[k] & ~vld_vec[map_q[k]];
  end

  assign missing = |miss_bits;
endmodule

// File: rtl/nl_sweep_ctrl.sv
module nl_sweep_ctrl
  import nl_pkg::*;
#(
  parameter int NG    = 256,
  parameter int NW    = 512,
  parameter int RES_W = 64,
  localparam int GIW = $clog2(NG),
  localparam int WIW = $clog2(NW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             g_present,
  input  logic [1:0]       g_op,
  input  logic [WIW-1:0]   g_dst,
  input  logic             a_val,
  input  logic             a_vld,
  input  logic             b_val,
  input  logic             b_vld,
  input  logic             d_vld,
  input  logic             missing,
  input  logic [RES_W-1:0] packed_word,
  output logic [GIW-1:0]   idx,
  output logic             eng_we,
  output logic [WIW-1:0]   eng_addr,
  output logic             eng_val,
  output logic             restore,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [RES_W-1:0] result
);
  localparam logic [GIW-1:0] LAST = GIW'(NG - 1);

  st_e              st_q, st_d;
  logic [GIW-1:0]   idx_q, idx_d;
  logic             fired_q, fired_d, pend_q, pend_d;
  logic [NG-1:0]    gdone_q, gdone_d;
  logic             done_q, done_d, err_q, err_d;
  logic [RES_W-1:0] res_q, res_d;
  logic active, bad_op, ready, clash, fire, bit_out, fired_now, pend_now;

  always_comb begin
    active  = (st_q == ST_SWEEP) && g_present && !gdone_q[idx_q];
    bad_op  = active && (op_e'(g_op) == OP_BAD);
    ready   = active && a_vld && b_vld && !bad_op;
    clash   = ready && d_vld;
    fire    = ready && !clash;
    unique case (op_e'(g_op))
      OP_AND:  bit_out = a_val & b_val;
      OP_OR:   bit_out = a_val | b_val;
      OP_XOR:  bit_out = a_val ^ b_val;
      default: bit_out = 1'b0;
    endcase
    fired_now = fired_q | fire;
    pend_now  = pend_q | (active && !fire);
  end

  always_comb begin
    st_d = st_q; idx_d = idx_q; fired_d = fired_q; pend_d = pend_q;
    gdone_d = gdone_q; err_d = err_q; res_d = res_q;
    done_d = 1'b0; restore = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_SWEEP; idx_d = '0; fired_d = 1'b0; pend_d = 1'b0;
        gdone_d = '0; err_d = 1'b0; res_d = '0; restore = 1'b1;
      end
      ST_SWEEP: begin
        if (bad_op || clash) begin
          err_d = 1'b1; st_d = ST_IDLE;
        end else begin
          if (fire) gdone_d[idx_q] = 1'b1;
          if (idx_q == LAST) begin
            idx_d = '0; fired_d = 1'b0; pend_d = 1'b0;
            if (!pend_now)       st_d = ST_PACK;
            else if (!fired_now) begin err_d = 1'b1; st_d = ST_IDLE; end
          end else begin
            idx_d = idx_q + 1'b1; fired_d = fired_now; pend_d = pend_now;
          end
        end
      end
      ST_PACK: begin
        st_d = ST_IDLE;
        if (missing) err_d = 1'b1;
        else begin res_d = packed_word; done_d = 1'b1; end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0; fired_q <= 1'b0; pend_q <= 1'b0;
      gdone_q <= '0; done_q <= 1'b0; err_q <= 1'b0; res_q <= '0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; fired_q <= fired_d; pend_q <= pend_d;
      gdone_q <= gdone_d; done_q <= done_d; err_q <= err_d; res_q <= res_d;
    end
  end

  assign idx      = idx_q;
  assign eng_we   = fire;
  assign eng_addr = g_dst;
  assign eng_val  = bit_out;
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign error    = err_q;
  assign result   = res_q;

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R4: a run never reports both outcomes at once
  a_r4_done_error_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q));
  // R7: the result word holds while idle with no start
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(res_q));
endmodule

// File: rtl/netlist_eval.sv
module netlist_eval #(
  parameter int NG    = 256,
  parameter int NW    = 512,
  parameter int RES_W = 64,
  localparam int GIW = $clog2(NG),
  localparam int WIW = $clog2(NW),
  localparam int PIW = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_clr,
  input  logic             gate_we,
  input  logic [GIW-1:0]   gate_addr,
  input  logic [1:0]       gate_op,
  input  logic [WIW-1:0]   gate_src_a,
  input  logic [WIW-1:0]   gate_src_b,
  input  logic [WIW-1:0]   gate_dst,
  input  logic             wire_we,
  input  logic [WIW-1:0]   wire_addr,
  input  logic             wire_val,
  input  logic             map_we,
  input  logic [PIW-1:0]   map_pos,
  input  logic [WIW-1:0]   map_wire,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [RES_W-1:0] result
);
  logic           host_ok, clr_en, gate_en, wire_en, map_en;
  logic [GIW-1:0] idx;
  logic           g_present;
  logic [1:0]     g_op;
  logic [WIW-1:0] g_a, g_b, g_dst;
  logic           a_val, a_vld, b_val, b_vld, d_vld;
  logic           eng_we, eng_val, restore, missing;
  logic [WIW-1:0] eng_addr;
  logic [NW-1:0]  val_vec, vld_vec;
  logic [RES_W-1:0] packed_word;

  assign host_ok = !busy;
  assign clr_en  = load_clr & host_ok;
  assign gate_en = gate_we  & host_ok;
  assign wire_en = wire_we  & host_ok;
  assign map_en  = map_we   & host_ok;

  nl_gate_table #(.NG(NG), .NW(NW)) i_table (
    .clk, .rst_n, .clr(clr_en), .we(gate_en), .waddr(gate_addr),
    .wop(gate_op), .wsrc_a(gate_src_a), .wsrc_b(gate_src_b), .wdst(gate_dst),
    .raddr(idx), .r_present(g_present), .r_op(g_op),
    .r_src_a(g_a), .r_src_b(g_b), .r_dst(g_dst));

  nl_wire_store #(.NW(NW)) i_wires (
    .clk, .rst_n, .clr(clr_en), .restore,
    .host_we(wire_en), .host_addr(wire_addr), .host_val(wire_val),
    .eng_we, .eng_addr, .eng_val,
    .rd_a(g_a), .rd_b(g_b), .rd_d(g_dst),
    .a_val, .a_vld, .b_val, .b_vld, .d_vld, .val_vec, .vld_vec);

  nl_result_pack #(.NW(NW), .RES_W(RES_W)) i_pack (
    .clk, .rst_n, .clr(clr_en), .we(map_en), .pos(map_pos), .wsel(map_wire),
    .val_vec, .vld_vec, .packed_word, .missing);

  nl_sweep_ctrl #(.NG(NG), .NW(NW), .RES_W(RES_W)) i_ctrl (
    .clk, .rst_n, .start, .g_present, .g_op, .g_dst,
    .a_val, .a_vld, .b_val, .b_vld, .d_vld, .missing, .packed_word,
    .idx, .eng_we, .eng_addr, .eng_val, .restore,
    .busy, .done, .error, .result);

  // R6: done is only reported when every mapped wire is known
  a_r6_done_mapped_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !missing);
endmodule

// File: tb/test_netlist_eval.sv
module test_netlist_eval;
  localparam int NG = 8, NW = 32, RW = 16;
  localparam int GIW = $clog2(NG), WIW = $clog2(NW), PIW = $clog2(RW);
  localparam time TCK = 8ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load_clr = 0, gate_we = 0, wire_we = 0, map_we = 0, start = 0, wire_val = 0;
  logic [GIW-1:0] gate_addr = '0;
  logic [1:0] gate_op = '0;
  logic [WIW-1:0] gate_src_a = '0, gate_src_b = '0, gate_dst = '0, wire_addr = '0, map_wire = '0;
  logic [PIW-1:0] map_pos = '0;
  logic busy, done, error;
  logic [RW-1:0] result;
  int n_run = 0, n_fail = 0;

  always #(TCK/2) clk = ~clk;

  netlist_eval #(.NG(NG), .NW(NW), .RES_W(RW)) i_netlist_eval (
    .clk, .rst_n, .load_clr, .gate_we, .gate_addr, .gate_op, .gate_src_a,
    .gate_src_b, .gate_dst, .wire_we, .wire_addr, .wire_val, .map_we,
    .map_pos, .map_wire, .start, .busy, .done, .error, .result);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_clr();
    @(negedge clk); load_clr = 1; @(negedge clk); load_clr = 0;
  endtask
  task automatic put_gate(int a, int op, int sa, int sb, int d);
    @(negedge clk); gate_we = 1; gate_addr = GIW'(a); gate_op = 2'(op);
    gate_src_a = WIW'(sa); gate_src_b = WIW'(sb); gate_dst = WIW'(d);
    @(negedge clk); gate_we = 0;
  endtask
  task automatic put_wire(int a, int v);
    @(negedge clk); wire_we = 1; wire_addr = WIW'(a); wire_val = 1'(v);
    @(negedge clk); wire_we = 0;
  endtask
  task automatic put_map(int p, int w);
    @(negedge clk); map_we = 1; map_pos = PIW'(p); map_wire = WIW'(w);
    @(negedge clk); map_we = 0;
  endtask

  // meddle=1: while busy, pulse start again and try a wire write
  task automatic run(input bit meddle, output logic d, output logic e, output int ndone);
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    d = 0; e = 0; ndone = 0;
    if (meddle) begin
      start = 1; wire_we = 1; wire_addr = '0; wire_val = 0; load_clr = 1;
      @(negedge clk); start = 0; wire_we = 0; load_clr = 0;
    end
    for (int i = 0; i < 3000 && !d && !e; i++) begin
      if (done) begin d = 1; ndone++; end
      if (error) e = 1;
      if (!d && !e) @(negedge clk);
    end
  endtask

  task automatic load_example();
    do_clr();
    put_wire(0, 1); put_wire(1, 1); put_wire(2, 1);
    put_wire(3, 0); put_wire(4, 1); put_wire(5, 0);
    put_gate(0, 0, 0, 3, 6); put_gate(1, 2, 1, 4, 7); put_gate(2, 1, 2, 5, 8);
    put_map(0, 6); put_map(1, 7); put_map(2, 8);
  endtask

  task automatic t_reset();
    chk("R9 busy after reset", 32'(busy), 0);
    chk("R9 done after reset", 32'(done), 0);
    chk("R9 error after reset", 32'(error), 0);
    chk("R9 result after reset", 32'(result), 0);
  endtask

  task automatic t_example();
    logic d, e; int nd;
    load_example();
    run(0, d, e, nd);
    chk("R10 done", 32'(d), 1);
    chk("R10 result", 32'(result), 4);
    @(negedge clk);
    chk("R7 done falls after one cycle", 32'(done), 0);
    repeat (5) @(negedge clk);
    chk("R7 result held", 32'(result), 4);
    // R11 rerun identical, then change x2 to 0
    run(0, d, e, nd);
    chk("R11 rerun result", 32'(result), 4);
    put_wire(2, 0);
    run(0, d, e, nd);
    chk("R11 rerun after input change", 32'(result), 0);
    chk("R11 rerun no error", 32'(e), 0);
  endtask

  task automatic t_ops();
    logic d, e; int nd;
    for (int c = 0; c < 4; c++) begin
      int p = c & 1; int q = c >> 1;
      do_clr();
      put_wire(0, p); put_wire(1, q);
      put_gate(0, 0, 0, 1, 2); put_gate(1, 1, 0, 1, 3); put_gate(2, 2, 0, 1, 4);
      put_map(0, 2); put_map(1, 3); put_map(2, 4);
      run(0, d, e, nd);
      chk("R1 op truth table", 32'(result), 32'(((p ^ q) << 2) | ((p | q) << 1) | (p & q)));
    end
  endtask

  task automatic t_chain();
    logic d, e; int nd;
    do_clr();
    put_wire(0, 1); put_wire(1, 1); put_wire(2, 0); put_wire(3, 0);
    put_gate(0, 0, 12, 3, 13); put_gate(1, 2, 11, 2, 12); put_gate(2, 0, 0, 1, 11);
    put_map(0, 13); put_map(1, 11); put_map(2, 12);
    run(0, d, e, nd);
    chk("R2 reverse chain done", 32'(d), 1);
    chk("R2 R5 reverse chain result", 32'(result), 32'h6);
  endtask

  task automatic t_errors();
    logic d, e; int nd;
    do_clr(); put_wire(0, 1); put_gate(0, 0, 20, 0, 21); put_map(0, 0);
    run(0, d, e, nd);
    chk("R4 stall error", 32'(e), 1);
    chk("R4 stall no done", 32'(nd), 0);
    chk("R4 idle after stall", 32'(busy), 0);
    do_clr(); put_wire(0, 1); put_wire(1, 0); put_gate(3, 3, 0, 1, 5);
    run(0, d, e, nd);
    chk("R1 illegal op error", 32'(e), 1);
    do_clr(); put_wire(0, 1); put_wire(1, 0); put_gate(0, 1, 0, 1, 0);
    run(0, d, e, nd);
    chk("R3 write to preset wire error", 32'(e), 1);
    do_clr(); put_wire(0, 1); put_wire(1, 0);
    put_gate(0, 1, 0, 1, 6); put_gate(4, 0, 0, 1, 6);
    run(0, d, e, nd);
    chk("R3 second driver error", 32'(e), 1);
    do_clr(); put_wire(0, 1); put_wire(1, 1); put_gate(0, 0, 0, 1, 6);
    put_map(0, 6); put_map(1, 30);
    run(0, d, e, nd);
    chk("R6 unknown mapped wire error", 32'(e), 1);
    chk("R6 no done", 32'(d), 0);
  endtask

  task automatic t_busy();
    logic d, e; int nd;
    load_example();
    run(0, d, e, nd);
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    chk("R7 result cleared by start", 32'(result), 0);
    chk("R8 busy after start", 32'(busy), 1);
    for (int i = 0; i < 200 && !done && !error; i++) @(negedge clk);
    chk("R8 run completes", 32'(done), 1);
    run(1, d, e, nd);
    chk("R8 writes and start ignored while busy", 32'(result), 4);
    chk("R8 single done", 32'(nd), 1);
    @(negedge clk);
    chk("R8 no second run", 32'(busy), 0);
  endtask

  task automatic t_clear();
    logic d, e; int nd;
    load_example();
    do_clr();
    run(0, d, e, nd);
    chk("R9 empty table done", 32'(d), 1);
    chk("R9 empty table result", 32'(result), 0);
  endtask

  initial begin
    #(TCK * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_example();
    t_ops();
    t_chain();
    t_errors();
    t_busy();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule